// File: doc/BRIEF.md
# Last-Dimension Sample Packer

This block turns a stream of fixed-width samples into words for transfer to memory. A signal is treated as rows of K samples each, where K is the size of its last dimension. In packed mode, the samples of one row are placed side by side in a single word. Sample 0 sits in the least significant bits, and the word is zero-padded up to a power-of-two width. In unpacked mode, each sample leaves as its own word, zero-extended into the smallest power-of-two container of at least 8 bits.

Samples enter over a valid/ready handshake that carries a row-end flag. Words leave over a valid/ready handshake from a registered output stage, and the row-end flag travels with each word. A row-end flag that arrives before the K-th sample closes the word early, with the unused lanes left at zero.

Sample width, K and mode are elaboration parameters. The product of K and the sample width must not exceed 512 bits.

Top module: `sample_packer`

## Requirements
- R1: After reset, o_valid is 0 and i_ready is 1.
- R2: In packed mode, sample k of a row is placed at o_word bits [k*SAMPLE_W +: SAMPLE_W], with sample 0 in the least significant bits. The word is offered after the K-th sample of the row is accepted.
- R3: Every o_word bit at or above the populated data width is 0. The populated data width is K*SAMPLE_W in packed mode and SAMPLE_W in unpacked mode.
- R4: In packed mode, an accepted sample with i_last=1 in lane j<K-1 closes the word early. Lanes above j are 0, and the next sample starts again in lane 0.
- R5: o_last equals the i_last value of the sample that completed the word.
- R6: In unpacked mode, every accepted sample becomes one word, and o_word[SAMPLE_W-1:0] equals that sample.
- R7: While o_valid=1 and o_ready=0, o_valid, o_word and o_last hold unchanged in the next cycle.
- R8: i_ready is 0 only when the offered sample would complete a word while the output holds a word that is not being taken. A sample that does not complete a word is accepted even while the output is stalled.
- R9: A word is on o_word with o_valid=1 in the cycle after its completing sample is accepted. This also holds when the previous word is taken in that same cycle.
- R10: The o_word width is the smallest power of two, at least 8, that is not less than the populated data width. For 10-bit samples this gives 32 bits with K=3 packed and 16 bits unpacked.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| i_valid | input | 1 | Sample offered |
| i_ready | output | 1 | Sample can be taken this cycle |
| i_sample | input | SAMPLE_W | Sample value |
| i_last | input | 1 | Sample ends its row |
| o_valid | output | 1 | Word offered |
| o_ready | input | 1 | Consumer takes the word |
| o_word | output | word width (R10) | Packed or containerised word |
| o_last | output | 1 | Word ends a row |

## Verification
Two things can happen in the same cycle: the output stage hands its word to the consumer, and the output stage loads the next word completed by an incoming sample. The bench provokes this by stalling o_ready and sending more samples. The first two samples of the next row are still accepted, and the row-closing sample is refused. The bench then raises o_ready while that closing sample is still offered. It judges the result by three things: the closing sample is accepted on that same edge, the old word is retired, and the new word with its row-end flag is visible in the very next cycle, with no bubble and no loss.

// File: rtl/spk_pkg.sv
package spk_pkg;
  function automatic int word_width(input int packed_mode, input int sample_w, input int lanes);
    int bits;
    int w;
    bits = (packed_mode != 0) ? sample_w * lanes : sample_w;
    w = 8;
    while (w < bits) w = w * 2;
    return w;
  endfunction
endpackage

// File: rtl/spk_lane_merge.sv
module spk_lane_merge #(
  parameter int SAMPLE_W = 10,
  parameter int LANES    = 3,
  parameter int IDX_W    = 2
) (
  input  logic [LANES*SAMPLE_W-1:0] acc,
  input  logic [SAMPLE_W-1:0]       sample,
  input  logic [IDX_W-1:0]          idx,
  output logic [LANES*SAMPLE_W-1:0] merged
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign merged[g*SAMPLE_W +: SAMPLE_W] =
      (idx == IDX_W'(g)) ? sample : acc[g*SAMPLE_W +: SAMPLE_W];
  end
endmodule

// File: rtl/spk_slot_ctrl.sv
module spk_slot_ctrl #(
  parameter int LANES = 3,
  parameter int IDX_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic             in_last,
  input  logic             out_free,
  output logic [IDX_W-1:0] idx,
  output logic             completes,
  output logic             ready,
  output logic             accept
);
  logic [IDX_W-1:0] cnt_q;

  assign idx       = cnt_q;
  assign completes = (cnt_q == IDX_W'(LANES - 1)) | in_last;
  assign ready     = out_free | ~completes;
  assign accept    = in_valid & ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (accept) begin
      cnt_q <= completes ? '0 : cnt_q + IDX_W'(1);
    end
  end
endmodule

// File: rtl/spk_out_reg.sv
module spk_out_reg #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] word,
  input  logic         last,
  input  logic         take,
  output logic         valid_q,
  output logic [W-1:0] word_q,
  output logic         last_q,
  output logic         free
);
  assign free = ~valid_q | take;

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= 1'b0;
      word_q  <= '0;
      last_q  <= 1'b0;
    end else if (load) begin
      valid_q <= 1'b1;
      word_q  <= word;
      last_q  <= last;
    end else if (take) begin
      valid_q <= 1'b0;
    end
  end
endmodule

// File: rtl/sample_packer.sv
module sample_packer #(
  parameter int SAMPLE_W = 10,
  parameter int K        = 3,
  parameter int PACKED   = 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                i_valid,
  output logic                i_ready,
  input  logic [SAMPLE_W-1:0] i_sample,
  input  logic                i_last,
  output logic                o_valid,
  input  logic                o_ready,
  output logic [spk_pkg::word_width(PACKED, SAMPLE_W, K)-1:0] o_word,
  output logic                o_last
);
  localparam int LANES  = (PACKED != 0) ? K : 1;
  localparam int IDX_W  = (LANES > 1) ? $clog2(LANES) : 1;
  localparam int DATA_W = LANES * SAMPLE_W;
  localparam int OUT_W  = spk_pkg::word_width(PACKED, SAMPLE_W, K);

  logic [DATA_W-1:0] acc_q;
  logic [DATA_W-1:0] merged;
  logic [IDX_W-1:0]  idx;
  logic              completes;
  logic              accept;
  logic              out_free;
  logic [OUT_W-1:0]  word_next;

  spk_slot_ctrl #(.LANES(LANES), .IDX_W(IDX_W)) i_ctrl (
    .clk(clk), .rst(rst), .in_valid(i_valid), .in_last(i_last),
    .out_free(out_free), .idx(idx), .completes(completes),
    .ready(i_ready), .accept(accept)
  );

  spk_lane_merge #(.SAMPLE_W(SAMPLE_W), .LANES(LANES), .IDX_W(IDX_W)) i_merge (
    .acc(acc_q), .sample(i_sample), .idx(idx), .merged(merged)
  );

  assign word_next = OUT_W'(merged);

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q <= '0;
    end else if (accept) begin
      acc_q <= completes ? '0 : merged;
    end
  end

  spk_out_reg #(.W(OUT_W)) i_out (
    .clk(clk), .rst(rst), .load(accept & completes), .word(word_next),
    .last(i_last), .take(o_ready), .valid_q(o_valid), .word_q(o_word),
    .last_q(o_last), .free(out_free)
  );
endmodule

// File: rtl/spk_checker.sv
module spk_checker #(
  parameter int SAMPLE_W = 10,
  parameter int LANES    = 3,
  parameter int OUT_W    = 32
) (
  input logic                clk,
  input logic                rst,
  input logic                i_valid,
  input logic                i_ready,
  input logic [SAMPLE_W-1:0] i_sample,
  input logic                i_last,
  input logic                o_valid,
  input logic                o_ready,
  input logic [OUT_W-1:0]    o_word,
  input logic                o_last
);
  localparam int DATA_W = LANES * SAMPLE_W;

  // R1
  reset_idle_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !o_valid && i_ready);

  // R7
  hold_stall_chk: assert property (@(posedge clk) disable iff (rst)
    o_valid && !o_ready |=> o_valid && $stable(o_word) && $stable(o_last));

  // R8
  refuse_only_full_chk: assert property (@(posedge clk) disable iff (rst)
    !i_ready |-> o_valid && !o_ready);

  // R9
  row_end_latency_chk: assert property (@(posedge clk) disable iff (rst)
    i_valid && i_ready && i_last |=> o_valid && o_last);

  // R3
  pad_zero_chk: assert property (@(posedge clk) disable iff (rst)
    o_valid |-> (o_word >> DATA_W) == '0);

  if (LANES == 1) begin : g_unp
    // R6
    unpacked_copy_chk: assert property (@(posedge clk) disable iff (rst)
      i_valid && i_ready |=> o_valid && o_word[SAMPLE_W-1:0] == $past(i_sample));
  end
endmodule

bind sample_packer spk_checker #(
  .SAMPLE_W(SAMPLE_W), .LANES(LANES), .OUT_W(OUT_W)
) i_chk (
  .clk(clk), .rst(rst), .i_valid(i_valid), .i_ready(i_ready),
  .i_sample(i_sample), .i_last(i_last), .o_valid(o_valid),
  .o_ready(o_ready), .o_word(o_word), .o_last(o_last)
);

// File: tb/test_sample_packer.sv
`timescale 1ns/1ps
module test_sample_packer;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  logic        p_valid = 1'b0, p_last = 1'b0, p_oready = 1'b1;
  logic [9:0]  p_sample = '0;
  logic        p_ready, p_ovalid, p_olast;
  logic [31:0] p_word;

  logic        u_valid = 1'b0, u_last = 1'b0, u_oready = 1'b1;
  logic [9:0]  u_sample = '0;
  logic        u_ready, u_ovalid, u_olast;
  logic [15:0] u_word;

  sample_packer #(.SAMPLE_W(10), .K(3), .PACKED(1)) i_sample_packer (
    .clk(clk), .rst(rst), .i_valid(p_valid), .i_ready(p_ready),
    .i_sample(p_sample), .i_last(p_last), .o_valid(p_ovalid),
    .o_ready(p_oready), .o_word(p_word), .o_last(p_olast)
  );

  sample_packer #(.SAMPLE_W(10), .K(3), .PACKED(0)) i_sample_packer_unpacked (
    .clk(clk), .rst(rst), .i_valid(u_valid), .i_ready(u_ready),
    .i_sample(u_sample), .i_last(u_last), .o_valid(u_ovalid),
    .o_ready(u_oready), .o_word(u_word), .o_last(u_olast)
  );

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] pk(input logic [9:0] a, input logic [9:0] b, input logic [9:0] c);
    return {2'b00, c, b, a};
  endfunction

  // hold a packed-instance sample until accepted
  task automatic push_p(input logic [9:0] s, input logic l);
    @(negedge clk);
    p_valid = 1'b1; p_sample = s; p_last = l;
    #1;
    while (!p_ready) begin @(negedge clk); #1; end
    @(posedge clk);
    #1 p_valid = 1'b0;
  endtask

  task automatic push_u(input logic [9:0] s, input logic l);
    @(negedge clk);
    u_valid = 1'b1; u_sample = s; u_last = l;
    #1;
    while (!u_ready) begin @(negedge clk); #1; end
    @(posedge clk);
    #1 u_valid = 1'b0;
  endtask

  task automatic t_reset;
    @(negedge clk); #2;
    chk(p_ovalid == 1'b0, "R1 o_valid after reset", 32'(p_ovalid), 0);
    chk(p_ready == 1'b1, "R1 i_ready after reset", 32'(p_ready), 1);
    chk($bits(p_word) == 32, "R10 packed width", $bits(p_word), 32);
    chk($bits(u_word) == 16, "R10 unpacked width", $bits(u_word), 16);
  endtask

  task automatic t_full_row;
    push_p(10'h123, 0);
    push_p(10'h2AB, 0);
    @(negedge clk); #2;
    chk(p_ovalid == 1'b0, "R2 no word before K samples", 32'(p_ovalid), 0);
    push_p(10'h055, 1);
    @(negedge clk); #2;
    chk(p_ovalid == 1'b1, "R9 word valid next cycle", 32'(p_ovalid), 1);
    chk(p_word == pk(10'h123, 10'h2AB, 10'h055), "R2 lane order", p_word, pk(10'h123, 10'h2AB, 10'h055));
    chk(p_olast == 1'b1, "R5 row end carried", 32'(p_olast), 1);
  endtask

  task automatic t_no_last;
    push_p(10'h3FF, 0);
    push_p(10'h3FF, 0);
    push_p(10'h3FF, 0);
    @(negedge clk); #2;
    chk(p_word == 32'h3FFF_FFFF, "R3 padding zero", p_word, 32'h3FFF_FFFF);
    chk(p_olast == 1'b0, "R5 no row end", 32'(p_olast), 0);
  endtask

  task automatic t_early_last;
    push_p(10'h001, 0);
    push_p(10'h3C3, 1);
    @(negedge clk); #2;
    chk(p_ovalid && p_word == pk(10'h001, 10'h3C3, 10'h000), "R4 short row", p_word, pk(10'h001, 10'h3C3, 10'h000));
    chk(p_olast == 1'b1, "R5 short row end", 32'(p_olast), 1);
    push_p(10'h111, 0);
    push_p(10'h222, 0);
    push_p(10'h333, 1);
    @(negedge clk); #2;
    chk(p_word == pk(10'h111, 10'h222, 10'h333), "R4 restart at lane 0", p_word, pk(10'h111, 10'h222, 10'h333));
  endtask

  task automatic t_stall;
    logic [31:0] w1;
    w1 = pk(10'h0AA, 10'h155, 10'h2F0);
    @(negedge clk); p_oready = 1'b0;
    push_p(10'h0AA, 0);
    push_p(10'h155, 0);
    push_p(10'h2F0, 1);
    push_p(10'h00F, 0);
    push_p(10'h0F0, 0);
    chk(1'b1, "R8 non-completing samples accepted while stalled", 0, 0);
    @(negedge clk);
    p_valid = 1'b1; p_sample = 10'h30C; p_last = 1'b1;
    #1;
    chk(p_ready == 1'b0, "R8 completing sample refused", 32'(p_ready), 0);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); #2;
      chk(p_ovalid && p_word == w1 && p_olast, "R7 held while stalled", p_word, w1);
    end
    p_oready = 1'b1;
    #1;
    chk(p_ready == 1'b1, "R8 ready once output drains", 32'(p_ready), 1);
    @(posedge clk);
    #1 p_valid = 1'b0;
    @(negedge clk); #2;
    chk(p_ovalid && p_word == pk(10'h00F, 10'h0F0, 10'h30C), "R9 load while draining", p_word, pk(10'h00F, 10'h0F0, 10'h30C));
    @(negedge clk); #2;
    chk(p_ovalid == 1'b0, "R9 word taken once", 32'(p_ovalid), 0);
  endtask

  task automatic t_unpacked;
    logic [9:0] vals [3] = '{10'h3FF, 10'h155, 10'h001};
    for (int i = 0; i < 3; i++) begin
      push_u(vals[i], i == 2);
      @(negedge clk); #2;
      chk(u_ovalid && u_word == {6'b0, vals[i]}, "R6 one word per sample", 32'(u_word), 32'({6'b0, vals[i]}));
      chk(u_olast == (i == 2), "R5 unpacked row end", 32'(u_olast), 32'(i == 2));
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    t_reset();
    t_full_row();
    t_no_last();
    t_early_last();
    t_stall();
    t_unpacked();
    repeat (2) @(negedge clk);
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule